// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the device-side protocol engine of a 1024-byte serial memory reached over a four-wire SPI link. Chip select, serial clock and serial data-in are brought into the system clock domain through two-stage synchronizers, and every serial clock edge is detected there. The engine decodes an 8-bit opcode, collects a 16-bit address, streams array or status bytes back on the serial output, and gathers write data into a page buffer.

When chip select rises at the end of a well-formed array write or status write, the engine starts a self-timed internal cycle. During that cycle it copies each buffered byte into a byte-wide array port, then holds a busy flag for a fixed number of system clocks. A separate status/protection unit keeps the write-enable latch and the protection bits. The engine sends that unit set and clear pulses and status-write strobes. The unit answers with the status bits and with permission flags that are sampled when a write is committed.

Hold handling is done elsewhere and reaches the engine as a pause level. The engine drives a separate enable for the tri-state serial output.

Top module: `spi_mem_engine`

## Requirements
- R1: The opcodes are decoded as follows: 0x03 array read, 0x02 array write, 0x06 latch set, 0x04 latch clear, 0x05 status read, 0x01 status write. Any other opcode makes the engine ignore the rest of the frame, so there is no output enable, no latch pulse and no array write.
- R2: Opcode, address and data are shifted most significant bit first. Input bits are taken on the rising serial clock edge. The serial output changes only in response to a falling serial clock edge.
- R3: An array read sends 0x03 followed by a 16-bit address whose top 6 bits are ignored. The byte at that address is returned first. The pointer then advances after every byte and wraps from 0x3FF to 0x000.
- R4: An array write sends 0x02, a 16-bit address and one or more data bytes. It commits on the chip-select rise only when arr_wr_ok_i is high. Each received byte then reaches the array at its own address during the internal cycle.
- R5: Write data that runs past the end of a PAGE_BYTES page wraps to the start of the same page and overwrites any byte already buffered there. Bytes never spill into the next page.
- R6: An array write whose chip-select rise does not fall exactly after bit 0 of a data byte, or that carries no data byte, is dropped. busy_o stays low and the array is unchanged.
- R7: Latch set (0x06) and latch clear (0x04) pulse wen_set_o and wen_clr_o respectively. Each pulse happens only when chip select rises right after exactly 8 bits. A latch set followed by further bits in the same frame has no effect.
- R8: A committed write holds busy_o high for WR_CYCLES system clocks and then pulses wen_clr_o. While busy_o is high, array reads, array writes and status writes are ignored. Status reads still work, and bit 0 of the returned byte is the busy flag.
- R9: A status write sends 0x01 and exactly one data byte. When stat_wr_ok_i is high, it pulses stat_we_o with that byte on stat_wdata_o and starts an internal cycle. Extra bits cancel it.
- R10: sdo_oe_o is low while chip select is high, while pause_i is high, and outside the read-data and status-data phases.
- R11: After reset, nothing is accepted until a falling edge of chip select has been seen. A frame that was already low at reset release is ignored.
- R12: While pause_i is high, serial clock edges are ignored. Once pause_i drops, the transfer resumes from the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low (asynchronous) |
| sck_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| pause_i | input | 1 | Pause level from the hold logic |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data-out driver |
| mem_addr_o | output | ADDR_W | Array address (read pointer, or write address while busy) |
| mem_rdata_i | input | 8 | Array read data, combinational on mem_addr_o |
| mem_we_o | output | 1 | Array byte write strobe |
| mem_wdata_o | output | 8 | Array write data |
| stat_i | input | 7 | Status bits 7..1 from the status unit |
| arr_wr_ok_i | input | 1 | Array write permitted (latch set, start address unprotected) |
| stat_wr_ok_i | input | 1 | Status write permitted |
| wen_set_o | output | 1 | Pulse: set the write-enable latch |
| wen_clr_o | output | 1 | Pulse: clear the write-enable latch |
| stat_we_o | output | 1 | Pulse: write the status byte |
| stat_wdata_o | output | 8 | Status byte to write |
| busy_o | output | 1 | Internal write cycle in progress |
| wr_addr_o | output | ADDR_W | Start address of the current array write command |

## Verification
The bench targets the points where a frame must be judged by its exact bit count. These cases are a write closed three bits past a byte, a latch set followed by one more bit, a latch set and a write in one frame, and a frame already low when reset is released. A design that counted loosely would commit these writes or set the latch. Address wrap is exercised twice: a page write that starts two bytes before the page end and runs over it (and another that overruns the whole page), and a sequential read that crosses 0x3FF. A design that carried into the next page or past the array top would return the wrong bytes. While a write cycle runs, the bench checks that an array read leaves the output disabled and that a status write is dropped. It also checks that a pause in the middle of a read loses no bit.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_RD_ARRAY  = 8'h03;
  localparam logic [7:0] OP_WR_ARRAY  = 8'h02;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADH, ST_ADL, ST_RD, ST_WR,
    ST_SRO, ST_SRI, ST_SRH, ST_ENH, ST_DIH, ST_SKIP
  } eng_st_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_v_i,
  input  logic [7:0]        byte_i,
  input  logic              go_arr_i,
  input  logic              go_stat_i,
  output logic              have_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam int TW = $clog2(WR_CYCLES + 1);

  logic [7:0]           pbuf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [ADDR_W-1:0]    start_q;
  logic [PB-1:0]        off_q;
  logic [PB:0]          wi_q;
  logic [TW-1:0]        tmr_q;
  logic                 busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= '0;
      vld_q   <= '0;
      start_q <= '0;
      off_q   <= '0;
      wi_q    <= '0;
      tmr_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        start_q <= start_addr_i;
        off_q   <= start_addr_i[PB-1:0];
        vld_q   <= '0;
      end else if (byte_v_i) begin
        pbuf_q[off_q] <= byte_i;
        vld_q[off_q]  <= 1'b1;
        off_q         <= off_q + 1'b1;  // wraps inside the page
      end
      if (go_arr_i || go_stat_i) begin
        busy_q <= 1'b1;
        wi_q   <= go_stat_i ? (PB+1)'(PAGE_BYTES) : '0;
        tmr_q  <= '0;
      end else if (busy_q) begin
        if (!wi_q[PB]) wi_q <= wi_q + 1'b1;
        tmr_q <= tmr_q + 1'b1;
        if (tmr_q == TW'(WR_CYCLES - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign have_data_o  = |vld_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign start_addr_o = start_q;
  assign mem_we_o     = busy_q && !wi_q[PB] && vld_q[wi_q[PB-1:0]];
  assign mem_addr_o   = {start_q[ADDR_W-1:PB], wi_q[PB-1:0]};
  assign mem_wdata_o  = pbuf_q[wi_q[PB-1:0]];

  // a new internal cycle is never requested while one runs
  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_arr_i || go_stat_i) |-> !busy_q);
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              pause_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:1]        stat_i,
  input  logic              arr_wr_ok_i,
  input  logic              stat_wr_ok_i,
  output logic              wen_set_o,
  output logic              wen_clr_o,
  output logic              stat_we_o,
  output logic [7:0]        stat_wdata_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [2:0] lvl, rse, fal;
  logic cs_l, sdi_l, cs_rise, cs_fall, rise, fall;

  spi_edge_sync #(.W(3)) u_sync (
    .clk_i, .rst_ni,
    .d_i({sdi_i, sck_i, cs_ni}),
    .lvl_o(lvl), .rise_o(rse), .fall_o(fal)
  );

  assign cs_l    = lvl[0];
  assign sdi_l   = lvl[2];
  assign cs_rise = rse[0];
  assign cs_fall = fal[0];
  assign rise    = rse[1] && !cs_l && !pause_i;
  assign fall    = fal[1] && !cs_l && !pause_i;

  eng_st_e           st_q;
  logic [2:0]        bitc_q, obit_q;
  logic [7:0]        sh_q, osh_q, sbyte_q;
  logic [HI_W-1:0]   adr_hi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rd_cmd_q, sdo_q;
  logic              set_q, clr_q, swe_q;
  logic [7:0]        rx_byte, out_src;
  logic              byte_end, pg_start, wr_byte_v, go_arr, go_stat;
  logic              busy, wr_done, have_data, wr_we;
  logic [ADDR_W-1:0] wr_addr;

  assign rx_byte   = {sh_q[6:0], sdi_l};
  assign byte_end  = rise && bitc_q == 3'd7;
  assign pg_start  = byte_end && st_q == ST_ADL && !rd_cmd_q;
  assign wr_byte_v = byte_end && st_q == ST_WR;
  assign go_arr    = cs_rise && st_q == ST_WR && bitc_q == 3'd0 && have_data
                     && arr_wr_ok_i && !busy;
  assign go_stat   = cs_rise && st_q == ST_SRH && stat_wr_ok_i && !busy;
  assign out_src   = (st_q == ST_RD) ? mem_rdata_i : {stat_i, busy};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bitc_q   <= '0;
      obit_q   <= '0;
      sh_q     <= '0;
      osh_q    <= '0;
      sbyte_q  <= '0;
      adr_hi_q <= '0;
      ptr_q    <= '0;
      rd_cmd_q <= 1'b0;
      sdo_q    <= 1'b0;
    end else if (cs_fall) begin
      st_q   <= ST_CMD;
      bitc_q <= '0;
      obit_q <= '0;
    end else if (cs_rise) begin
      st_q <= ST_IDLE;
    end else if (rise) begin
      bitc_q <= bitc_q + 1'b1;
      sh_q   <= rx_byte;
      if (st_q inside {ST_ENH, ST_DIH, ST_SRH}) st_q <= ST_SKIP;
      else if (bitc_q == 3'd7) begin
        unique case (st_q)
          ST_CMD: begin
            rd_cmd_q <= rx_byte == OP_RD_ARRAY;
            unique case (rx_byte)
              OP_RD_ARRAY, OP_WR_ARRAY: st_q <= busy ? ST_SKIP : ST_ADH;
              OP_LATCH_SET:             st_q <= ST_ENH;
              OP_LATCH_CLR:             st_q <= ST_DIH;
              OP_STAT_RD:               st_q <= ST_SRO;
              OP_STAT_WR:               st_q <= busy ? ST_SKIP : ST_SRI;
              default:                  st_q <= ST_SKIP;
            endcase
          end
          ST_ADH: begin
            adr_hi_q <= rx_byte[HI_W-1:0];
            st_q     <= ST_ADL;
          end
          ST_ADL: begin
            ptr_q <= {adr_hi_q, rx_byte};
            st_q  <= rd_cmd_q ? ST_RD : ST_WR;
          end
          ST_SRI: begin
            sbyte_q <= rx_byte;
            st_q    <= ST_SRH;
          end
          default: ;
        endcase
      end
    end else if (fall && (st_q == ST_RD || st_q == ST_SRO)) begin
      obit_q <= obit_q + 1'b1;
      if (obit_q == 3'd0) begin
        sdo_q <= out_src[7];
        osh_q <= {out_src[6:0], 1'b0};
        if (st_q == ST_RD) ptr_q <= ptr_q + 1'b1;  // wraps over the whole array
      end else begin
        sdo_q <= osh_q[7];
        osh_q <= {osh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= 1'b0;
      clr_q <= 1'b0;
      swe_q <= 1'b0;
    end else begin
      set_q <= cs_rise && st_q == ST_ENH;
      clr_q <= (cs_rise && st_q == ST_DIH) || wr_done;
      swe_q <= go_stat;
    end
  end

  spi_page_writer #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
  ) u_writer (
    .clk_i, .rst_ni,
    .start_i(pg_start),
    .start_addr_i({adr_hi_q, rx_byte}),
    .byte_v_i(wr_byte_v),
    .byte_i(rx_byte),
    .go_arr_i(go_arr),
    .go_stat_i(go_stat),
    .have_data_o(have_data),
    .busy_o(busy),
    .done_o(wr_done),
    .start_addr_o(wr_addr_o),
    .mem_we_o(wr_we),
    .mem_addr_o(wr_addr),
    .mem_wdata_o(mem_wdata_o)
  );

  assign mem_we_o     = wr_we;
  assign mem_addr_o   = busy ? wr_addr : ptr_q;
  assign sdo_o        = sdo_q;
  assign sdo_oe_o     = !cs_ni && !cs_l && !pause_i && (st_q == ST_RD || st_q == ST_SRO);
  assign wen_set_o    = set_q;
  assign wen_clr_o    = clr_q;
  assign stat_we_o    = swe_q;
  assign stat_wdata_o = sbyte_q;
  assign busy_o       = busy;

  assert_oe_hiz_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_l || pause_i) |-> !sdo_oe_o);
  assert_read_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD) |-> !busy);
  assert_start_on_cs_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cs_rise));
  assert_sdo_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(sdo_q));
  assert_set_on_cs_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_set_o |-> $past(cs_rise));
endmodule

// File: tb/spi_mem_engine_test.sv
module spi_mem_engine_test;
  localparam int ADDR_W = 10;
  localparam int PAGE   = 16;
  localparam int TWR    = 1500;
  localparam int HALF   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, sdi = 1'b0, pause = 1'b0;
  logic sdo, sdo_oe, mem_we, wen_set, wen_clr, stat_we, busy;
  logic [ADDR_W-1:0] mem_addr, wr_addr;
  logic [7:0] mem_wdata, stat_wdata;
  logic [7:0] mem [1024];
  logic [7:0] exp_mem [1024];
  logic wel_m = 1'b0;
  logic [7:2] sreg_m = '0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  spi_mem_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .WR_CYCLES(TWR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .pause_i(pause), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem[mem_addr]), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .stat_i({sreg_m, wel_m}), .arr_wr_ok_i(wel_m), .stat_wr_ok_i(wel_m),
    .wen_set_o(wen_set), .wen_clr_o(wen_clr), .stat_we_o(stat_we),
    .stat_wdata_o(stat_wdata), .busy_o(busy), .wr_addr_o(wr_addr)
  );

  // array and status-unit models
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (wen_set) wel_m <= 1'b1;
    else if (wen_clr) wel_m <= 1'b0;
    if (stat_we) sreg_m <= stat_wdata[7:2];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sdi = b;
    tick(HALF);
    r = sdo;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_io(tx[i], rx[i]);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic cs_hi();
    tick(2);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 5000) begin tick(1); k++; end
    tick(4);
  endtask

  task automatic rd_status(output logic [7:0] s);
    cs_lo(); send(8'h05); xfer(8'h00, s); cs_hi();
  endtask

  task automatic latch_set();
    cs_lo(); send(8'h06); cs_hi();
  endtask

  task automatic rd_check(input string req, input int a, input int n);
    logic [7:0] d;
    cs_lo(); send(8'hFC | 8'((a >> 8) & 3)); send(8'(a));
    cs_n = 1'b1; tick(6);  // placeholder cleared below
    cs_lo(); send(8'h03); send(8'hFC | 8'((a >> 8) & 3)); send(8'(a));
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      chk(req, $sformatf("read @%0h", (a + i) & 1023), d, exp_mem[(a + i) & 1023]);
    end
    cs_hi();
  endtask

  task automatic wr_frame(input int a, input int n, input logic [7:0] seed);
    cs_lo(); send(8'h02); send(8'h00 | 8'((a >> 8) & 3)); send(8'(a));
    for (int i = 0; i < n; i++) send(seed + 8'(i));
  endtask

  task t_reset_and_arm();
    logic [7:0] s;
    chk("R10", "oe after reset", sdo_oe, 1'b0);
    chk("R8", "busy after reset", busy, 1'b0);
    chk("R4", "we after reset", mem_we, 1'b0);
    // chip select already low at reset release: frame must be ignored (R11)
    send(8'h06); cs_hi();
    chk("R11", "latch after unarmed frame", wel_m, 1'b0);
    rd_status(s);
    chk("R11", "status after unarmed frame", s, 8'h00);
  endtask

  task t_unknown();
    logic [7:0] d;
    cs_lo(); send(8'hA5); xfer(8'h00, d);
    chk("R1", "oe after unknown opcode", sdo_oe, 1'b0);
    cs_hi();
    chk("R1", "latch after unknown opcode", wel_m, 1'b0);
  endtask

  task t_latch();
    logic [7:0] s;
    latch_set(); rd_status(s);
    chk("R7", "status after latch set", s, 8'h02);
    cs_lo(); send(8'h04); cs_hi(); rd_status(s);
    chk("R7", "status after latch clear", s, 8'h00);
    cs_lo(); send(8'h06); bit_io(1'b0, s[0]); cs_hi();
    chk("R7", "latch set plus one bit", wel_m, 1'b0);
    // set and write in one frame: nothing happens
    cs_lo(); send(8'h06); send(8'h02); send(8'h00); send(8'h20); send(8'h99); cs_hi();
    chk("R7", "busy after same-frame write", busy, 1'b0);
    chk("R7", "latch after same-frame write", wel_m, 1'b0);
    chk("R4", "array untouched", mem[10'h020], exp_mem[10'h020]);
  endtask

  task t_byte_write();
    logic [7:0] s;
    latch_set();
    cs_lo(); send(8'h02); send(8'hFD); send(8'h55); send(8'hC3); cs_hi();
    chk("R4", "busy after commit", busy, 1'b1);
    chk("R4", "write start address", wr_addr, 10'h155);
    rd_status(s);
    chk("R8", "status during cycle", s, 8'h03);
    wait_idle();
    exp_mem[10'h155] = 8'hC3;
    chk("R8", "latch cleared at end", wel_m, 1'b0);
    rd_check("R3", 10'h154, 3);
  endtask

  task t_no_latch();
    wr_frame(10'h0C0, 1, 8'h77); cs_hi();
    chk("R4", "no cycle without permission", busy, 1'b0);
    chk("R4", "array unchanged without permission", mem[10'h0C0], exp_mem[10'h0C0]);
  endtask

  task t_page_wrap();
    latch_set();
    wr_frame(10'h0AE, 4, 8'h11); cs_hi(); wait_idle();
    exp_mem[10'h0AE] = 8'h11; exp_mem[10'h0AF] = 8'h12;
    exp_mem[10'h0A0] = 8'h13; exp_mem[10'h0A1] = 8'h14;
    chk("R5", "next page untouched", mem[10'h0B0], exp_mem[10'h0B0]);
    rd_check("R5", 10'h0AE, 4);
    rd_check("R5", 10'h0A0, 3);
    latch_set();
    wr_frame(10'h200, PAGE + 1, 8'h80); cs_hi(); wait_idle();
    for (int i = 0; i < PAGE; i++) exp_mem[10'h200 + i] = 8'h80 + 8'(i);
    exp_mem[10'h200] = 8'h80 + 8'(PAGE);
    rd_check("R5", 10'h200, 2);
    rd_check("R5", 10'h200 + PAGE - 1, 2);
  endtask

  task t_abort();
    logic [7:0] s;
    latch_set();
    wr_frame(10'h300, 1, 8'h5A);
    for (int i = 0; i < 3; i++) bit_io(1'b1, s[0]);
    cs_hi();
    chk("R6", "no cycle off boundary", busy, 1'b0);
    chk("R6", "array unchanged off boundary", mem[10'h300], exp_mem[10'h300]);
    wr_frame(10'h301, 0, 8'h00); cs_hi();
    chk("R6", "no cycle without data", busy, 1'b0);
    chk("R6", "latch kept after abort", wel_m, 1'b1);
    cs_lo(); send(8'h04); cs_hi();
  endtask

  task t_seq_wrap();
    rd_check("R3", 10'h3FE, 4);
  endtask

  task t_busy();
    logic [7:0] s, d;
    latch_set();
    wr_frame(10'h010, 1, 8'hE7); cs_hi();
    exp_mem[10'h010] = 8'hE7;
    cs_lo(); send(8'h03); send(8'h00); send(8'h10); xfer(8'h00, d);
    chk("R8", "oe during busy array read", sdo_oe, 1'b0);
    cs_hi();
    cs_lo(); send(8'h01); send(8'hFC); cs_hi();
    chk("R8", "status write dropped while busy", stat_we, 1'b0);
    wait_idle();
    rd_status(s);
    chk("R8", "status after cycle", s, 8'h00);
    rd_check("R8", 10'h010, 1);
  endtask

  task t_status_write();
    logic [7:0] s;
    latch_set();
    cs_lo(); send(8'h01); send(8'hF4); bit_io(1'b0, s[0]); cs_hi();
    chk("R9", "status write with extra bit", busy, 1'b0);
    cs_lo(); send(8'h01); send(8'hF4); cs_hi();
    chk("R9", "status write starts cycle", busy, 1'b1);
    wait_idle();
    rd_status(s);
    chk("R9", "status byte written", s, 8'hF4);
  endtask

  task t_pause_oe();
    logic [7:0] d;
    cs_lo(); send(8'h03); send(8'h00); send(8'h40);
    xfer(8'h00, d);
    chk("R3", "first byte before pause", d, exp_mem[10'h040]);
    chk("R10", "oe in read phase", sdo_oe, 1'b1);
    pause = 1'b1; tick(2);
    chk("R10", "oe during pause", sdo_oe, 1'b0);
    for (int i = 0; i < 8; i++) begin
      sdi = 1'(i); tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    pause = 1'b0; tick(2);
    xfer(8'h00, d);
    chk("R12", "byte after pause", d, exp_mem[10'h041]);
    cs_n = 1'b1; #1;
    chk("R10", "oe at cs high", sdo_oe, 1'b0);
    tick(8);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset_and_arm();
    t_unknown();
    t_latch();
    t_byte_write();
    t_no_latch();
    t_page_wrap();
    t_abort();
    t_seq_wrap();
    t_busy();
    t_status_write();
    t_pause_oe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule